// File: doc/BRIEF.md
# Multi-Mode Programmable Down-Counter Channel

This block is a single binary down-counting timer channel. It counts on a single-cycle count-enable tick, not on every clock. Software-side logic hands it a reload value, a mode number and a load strobe. A separate gate input controls it, acting either as a level that holds counting or as a rising-edge trigger, depending on the mode. The channel drives one output waveform and shows its current count. It also has a flag that rises once the first value has been loaded.

There are six waveform modes:

| Mode | Behaviour |
|------|-----------|
| 0 | A sticky output that rises at terminal count. |
| 1 | A retriggerable one-shot. |
| 2 | A periodic one-tick pulse. |
| 3 | A near-symmetric square wave. |
| 4 | A single software-started one-tick strobe. |
| 5 | A single strobe that a gate edge can restart. |

The mode input is three bits wide. Its two spare codes reuse the periodic modes. Byte sequencing, read latching and address decoding sit in a neighbouring register block. The reset input is expected to be already synchronised to the clock.

Top module: `tmr_chan`

## Requirements
- R1: After reset `chan_out` is 0, `count_loaded` is 0 and `count_val` is 0. Ticks change none of them until the first load.
- R2: A reload value of 0 gives a period of 65536 ticks. `count_val` shows 0 right after the load and 65535 after one counted tick.
- R3: Mode 0 (`mode_sel`=0) drives the output low on load. The output goes high on the N-th counted tick and stays high until the next load. Gate low holds the count.
- R4: Mode 1 drives the output low on load and counts whatever the gate level is. The output goes high on the N-th tick. A gate rising edge reloads N and drives the output low again.
- R5: Mode 2 gives a one-tick-wide high pulse on every N-th counted tick, reloading N at that point. Between pulses the output is low.
- R6: Mode 3 drives the output high on load. The count steps down by two per tick. The output stays high for (N+1)/2 ticks and low for the other N-(N+1)/2 ticks of each N-tick period. An odd N loads N+1 for the high half and N-1 for the low half.
- R7: Mode 4 pulses the output high for exactly one tick on the N-th counted tick and then never again. Gate low holds the count. A gate rising edge does not restart it.
- R8: Mode 5 pulses like mode 4, but counts regardless of gate level. A gate rising edge restarts it from N.
- R9: `mode_sel` codes 6 and 7 behave exactly as codes 2 and 3.
- R10: A load in modes 2 or 3 that keeps the same mode updates only the reload value. That value is used at the next reload point, and a tick in the load cycle still counts. Every other load restarts the count at once.
- R11: In modes 2 and 3, gate low holds the count. A gate rising edge reloads N and returns the output to its start level.
- R12: `count_val` changes only on a tick, a load, or a gate rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count-enable tick, one cycle wide |
| gate_in | input | 1 | Gate: a level that holds counting, or an edge that triggers, depending on mode |
| load_stb | input | 1 | Load strobe for `load_val` and `mode_sel` |
| load_val | input | 16 | Reload value; 0 means 65536 |
| mode_sel | input | 3 | Mode number 0 to 7 |
| chan_out | output | 1 | Channel output waveform |
| count_val | output | 16 | Current count, low 16 bits |
| count_loaded | output | 1 | High once any load has occurred |

## Verification
A wrong count register shows up on `count_val` at the very next sampled clock. It then shifts the output edge by the same number of ticks, so it appears in at most one period. A wrong phase or one-shot-done bit does not touch the count. It shows only as a missing, extra or inverted output level at the next terminal or half-period point. For that reason the bench samples `chan_out` on both sides of each such point. A deferred-reload fault only shows one period after the load, so the bench runs past the next reload to catch it.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [2:0] {
    MD_TC_STICKY = 3'd0,
    MD_ONESHOT   = 3'd1,
    MD_RATE      = 3'd2,
    MD_SQUARE    = 3'd3,
    MD_SW_STROBE = 3'd4,
    MD_HW_STROBE = 3'd5
  } tmr_mode_e;
endpackage

// File: rtl/tmr_mode_map.sv
module tmr_mode_map
  import tmr_pkg::*;
(
  input  logic [2:0] raw_i,
  output tmr_mode_e  mode_o
);
  always_comb begin
    unique case (raw_i)
      3'd0:    mode_o = MD_TC_STICKY;
      3'd1:    mode_o = MD_ONESHOT;
      3'd2:    mode_o = MD_RATE;
      3'd3:    mode_o = MD_SQUARE;
      3'd4:    mode_o = MD_SW_STROBE;
      3'd5:    mode_o = MD_HW_STROBE;
      3'd6:    mode_o = MD_RATE;     // spare code reuses the rate mode
      default: mode_o = MD_SQUARE;   // spare code reuses the square mode
    endcase
  end
endmodule

// File: rtl/tmr_gate_edge.sv
module tmr_gate_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_i,
  output logic rise_o
);
  logic gate_q;
  logic gate_d;

  always_comb gate_d = gate_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate_d;
  end

  assign rise_o = gate_i & ~gate_q;
endmodule

// File: rtl/tmr_down_core.sv
module tmr_down_core
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         gate_i,
  input  logic         gate_rise_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  tmr_mode_e    load_mode_i,
  output logic         out_o,
  output logic [W-1:0] cnt_o,
  output logic         armed_o,
  output tmr_mode_e    mode_o
);
  localparam int CW = W + 1;
  localparam logic [CW-1:0] FULL = {1'b1, {W{1'b0}}};
  localparam logic [CW-1:0] ONE  = CW'(1);
  localparam logic [CW-1:0] TWO  = CW'(2);

  function automatic logic [CW-1:0] span_of(input logic [W-1:0] v);
    if (v == '0) return FULL;
    return {1'b0, v};
  endfunction

  function automatic logic [CW-1:0] first_load(input tmr_mode_e m, input logic [CW-1:0] p);
    if (m == MD_SQUARE) return p + {{(CW-1){1'b0}}, p[0]};
    return p;
  endfunction

  logic [CW-1:0] cnt_q,  cnt_d;
  logic [W-1:0]  rld_q,  rld_d;
  tmr_mode_e     mode_q, mode_d;
  logic          out_q,  out_d;
  logic          done_q, done_d;
  logic          armed_q, armed_d;

  logic [CW-1:0] per;
  logic [CW-1:0] odd_adj;
  logic          lvl_gated, retrig, pulse_md, run, defer;

  always_comb begin
    per       = span_of(rld_q);
    odd_adj   = {{(CW-1){1'b0}}, per[0]};
    lvl_gated = (mode_q inside {MD_TC_STICKY, MD_RATE, MD_SQUARE, MD_SW_STROBE});
    retrig    = (mode_q inside {MD_ONESHOT, MD_RATE, MD_SQUARE, MD_HW_STROBE});
    pulse_md  = (mode_q inside {MD_RATE, MD_SW_STROBE, MD_HW_STROBE});
    run       = armed_q & tick_i & ~done_q & (gate_i | ~lvl_gated);
    defer     = armed_q & (load_mode_i == mode_q) & (mode_q inside {MD_RATE, MD_SQUARE});
  end

  always_comb begin
    cnt_d   = cnt_q;
    rld_d   = rld_q;
    mode_d  = mode_q;
    out_d   = out_q;
    done_d  = done_q;
    armed_d = armed_q;

    // a pulse mode drops its output on the tick after it was raised
    if (armed_q && tick_i && pulse_md) out_d = 1'b0;

    if (run) begin
      unique case (mode_q)
        MD_RATE: begin
          if (cnt_q == ONE) begin
            cnt_d = per;
            out_d = 1'b1;
          end else begin
            cnt_d = cnt_q - ONE;
          end
        end
        MD_SQUARE: begin
          if (cnt_q <= TWO) begin
            if (out_q && (per != ONE)) begin
              out_d = 1'b0;
              cnt_d = per - odd_adj;
            end else begin
              out_d = 1'b1;
              cnt_d = per + odd_adj;
            end
          end else begin
            cnt_d = cnt_q - TWO;
          end
        end
        default: begin
          if (cnt_q == ONE) begin
            cnt_d  = '0;
            done_d = 1'b1;
            out_d  = 1'b1;
          end else begin
            cnt_d = cnt_q - ONE;
          end
        end
      endcase
    end

    if (armed_q && gate_rise_i && retrig) begin
      cnt_d  = first_load(mode_q, per);
      out_d  = (mode_q == MD_SQUARE);
      done_d = 1'b0;
    end

    if (load_i) begin
      rld_d   = load_val_i;
      mode_d  = load_mode_i;
      armed_d = 1'b1;
      if (!defer) begin
        cnt_d  = first_load(load_mode_i, span_of(load_val_i));
        out_d  = (load_mode_i == MD_SQUARE);
        done_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      rld_q   <= '0;
      mode_q  <= MD_TC_STICKY;
      out_q   <= 1'b0;
      done_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      rld_q   <= rld_d;
      mode_q  <= mode_d;
      out_q   <= out_d;
      done_q  <= done_d;
      armed_q <= armed_d;
    end
  end

  assign out_o   = out_q;
  assign cnt_o   = cnt_q[W-1:0];
  assign armed_o = armed_q;
  assign mode_o  = mode_q;
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         gate_in,
  input  logic         load_stb,
  input  logic [W-1:0] load_val,
  input  logic [2:0]   mode_sel,
  output logic         chan_out,
  output logic [W-1:0] count_val,
  output logic         count_loaded
);
  tmr_mode_e load_mode;
  tmr_mode_e mode_cur;
  logic      gate_rise;

  tmr_mode_map u_map (
    .raw_i  (mode_sel),
    .mode_o (load_mode)
  );

  tmr_gate_edge u_gate (
    .clk    (clk),
    .rst_n  (rst_n),
    .gate_i (gate_in),
    .rise_o (gate_rise)
  );

  tmr_down_core #(.W(W)) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_en),
    .gate_i      (gate_in),
    .gate_rise_i (gate_rise),
    .load_i      (load_stb),
    .load_val_i  (load_val),
    .load_mode_i (load_mode),
    .out_o       (chan_out),
    .cnt_o       (count_val),
    .armed_o     (count_loaded),
    .mode_o      (mode_cur)
  );
endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick_en,
  input logic         gate_in,
  input logic         load_stb,
  input logic         chan_out,
  input logic [W-1:0] count_val,
  input logic         count_loaded,
  input tmr_mode_e    mode_cur
);
  // R1: nothing moves before the first load
  a_r1_idle_until_load: assert property (@(posedge clk) disable iff (!rst_n)
    !count_loaded |-> (!chan_out && count_val == '0));

  // R3: terminal-count output stays high until a load
  a_r3_tc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (count_loaded && mode_cur == MD_TC_STICKY && chan_out && !load_stb) |=> chan_out);

  // R7 / R8: strobe lasts a single tick
  a_r7_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_cur inside {MD_SW_STROBE, MD_HW_STROBE}) && chan_out && tick_en && !load_stb)
      |=> !chan_out);

  // R6: square mode steps by two while mid-phase
  a_r6_half_step: assert property (@(posedge clk) disable iff (!rst_n)
    (count_loaded && mode_cur == MD_SQUARE && tick_en && gate_in && !load_stb &&
     !$rose(gate_in) && count_val > W'(2))
      |=> count_val == $past(count_val) - W'(2));

  // R12: count is frozen without tick, load or gate edge
  a_r12_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !load_stb && !$rose(gate_in)) |=> $stable(count_val));
endmodule

bind tmr_chan tmr_chan_chk #(.W(W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tick_en      (tick_en),
  .gate_in      (gate_in),
  .load_stb     (load_stb),
  .chan_out     (chan_out),
  .count_val    (count_val),
  .count_loaded (count_loaded),
  .mode_cur     (mode_cur)
);

// File: tb/sim_tmr_chan.sv
module sim_tmr_chan;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_en;
  logic        gate_in;
  logic        load_stb;
  logic [15:0] load_val;
  logic [2:0]  mode_sel;
  logic        chan_out;
  logic [15:0] count_val;
  logic        count_loaded;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  tmr_chan u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .gate_in(gate_in),
    .load_stb(load_stb), .load_val(load_val), .mode_sel(mode_sel),
    .chan_out(chan_out), .count_val(count_val), .count_loaded(count_loaded)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_load(input logic [2:0] m, input logic [15:0] v);
    load_stb = 1'b1; load_val = v; mode_sel = m;
    @(negedge clk);
    load_stb = 1'b0;
  endtask

  task automatic t_reset;
    tick_en = 1'b1;
    step(5);
    chk("R1 out", chan_out, 0);
    chk("R1 loaded", count_loaded, 0);
    chk("R1 count", count_val, 0);
  endtask

  task automatic t_mode0;
    gate_in = 1'b1;
    do_load(3'd0, 16'd5);
    chk("R3 count after load", count_val, 5);
    chk("R3 out after load", chan_out, 0);
    chk("R1 loaded flag", count_loaded, 1);
    step(4); chk("R3 out before tc", chan_out, 0); chk("R3 count", count_val, 1);
    step(1); chk("R3 out at tc", chan_out, 1);
    step(3); chk("R3 out sticky", chan_out, 1);
    gate_in = 1'b0;
    do_load(3'd0, 16'd4);
    step(3); chk("R3 gate hold count", count_val, 4); chk("R3 gate hold out", chan_out, 0);
    gate_in = 1'b1;
    step(3); chk("R3 resume count", count_val, 1); chk("R3 resume out", chan_out, 0);
    step(1); chk("R3 resume tc", chan_out, 1);
  endtask

  task automatic t_zero;
    do_load(3'd0, 16'd0);
    chk("R2 count low bits", count_val, 0);
    step(1); chk("R2 first tick", count_val, 65535);
    step(65534); chk("R2 out before end", chan_out, 0); chk("R2 count", count_val, 1);
    step(1); chk("R2 out at 65536", chan_out, 1);
  endtask

  task automatic t_mode1;
    gate_in = 1'b0;
    do_load(3'd1, 16'd3);
    chk("R4 out after load", chan_out, 0);
    step(2); chk("R4 count gate low", count_val, 1); chk("R4 out", chan_out, 0);
    step(1); chk("R4 out high", chan_out, 1);
    gate_in = 1'b1;
    step(1); chk("R4 retrigger count", count_val, 3); chk("R4 retrigger out", chan_out, 0);
    step(2); chk("R4 out low", chan_out, 0);
    step(1); chk("R4 out high again", chan_out, 1);
    step(2); chk("R4 no retrigger on level", chan_out, 1);
  endtask

  task automatic t_mode2;
    gate_in = 1'b1;
    do_load(3'd2, 16'd4);
    chk("R5 out after load", chan_out, 0); chk("R5 count", count_val, 4);
    step(3); chk("R5 before pulse", chan_out, 0); chk("R5 count", count_val, 1);
    step(1); chk("R5 pulse", chan_out, 1); chk("R5 reload", count_val, 4);
    step(1); chk("R5 pulse width", chan_out, 0);
    step(2); chk("R5 between", chan_out, 0);
    step(1); chk("R5 second pulse", chan_out, 1);
  endtask

  task automatic t_mode3;
    do_load(3'd0, 16'd9);
    do_load(3'd3, 16'd5);
    chk("R6 out after load", chan_out, 1); chk("R6 odd load", count_val, 6);
    step(1); chk("R6 step2", count_val, 4); chk("R6 high", chan_out, 1);
    step(1); chk("R6 high 3rd", chan_out, 1);
    step(1); chk("R6 low phase", chan_out, 0); chk("R6 low load", count_val, 4);
    step(1); chk("R6 low 2nd", chan_out, 0);
    step(1); chk("R6 high again", chan_out, 1); chk("R6 reload", count_val, 6);
    do_load(3'd0, 16'd9);
    do_load(3'd3, 16'd4);
    chk("R6 even load", count_val, 4);
    step(2); chk("R6 even low", chan_out, 0);
    step(2); chk("R6 even high", chan_out, 1);
  endtask

  task automatic t_mode4;
    gate_in = 1'b1;
    do_load(3'd4, 16'd3);
    step(2); chk("R7 before", chan_out, 0); chk("R7 count", count_val, 1);
    step(1); chk("R7 pulse", chan_out, 1);
    step(1); chk("R7 pulse end", chan_out, 0);
    step(10); chk("R7 no repeat", chan_out, 0);
    gate_in = 1'b0;
    do_load(3'd4, 16'd2);
    step(5); chk("R7 gate hold", count_val, 2);
    gate_in = 1'b1;
    step(1); chk("R7 no restart on edge", count_val, 1);
    step(1); chk("R7 pulse after resume", chan_out, 1);
  endtask

  task automatic t_mode5;
    gate_in = 1'b1;
    do_load(3'd5, 16'd3);
    step(3); chk("R8 pulse", chan_out, 1);
    step(1); chk("R8 pulse end", chan_out, 0);
    gate_in = 1'b0; step(1);
    gate_in = 1'b1; step(1);
    chk("R8 restart count", count_val, 3); chk("R8 restart out", chan_out, 0);
    step(2); chk("R8 count", count_val, 1);
    step(1); chk("R8 second pulse", chan_out, 1);
  endtask

  task automatic t_alias;
    do_load(3'd6, 16'd2);
    chk("R9 code6 load", count_val, 2); chk("R9 code6 out", chan_out, 0);
    step(1); chk("R9 code6 count", count_val, 1);
    step(1); chk("R9 code6 pulse", chan_out, 1); chk("R9 code6 reload", count_val, 2);
    do_load(3'd7, 16'd2);
    chk("R9 code7 start high", chan_out, 1);
    step(1); chk("R9 code7 half", chan_out, 0);
  endtask

  task automatic t_defer;
    do_load(3'd2, 16'd4);
    step(1); chk("R10 pre", count_val, 3);
    do_load(3'd2, 16'd6);
    chk("R10 no restart", count_val, 2);
    step(1); chk("R10 count", count_val, 1);
    step(1); chk("R10 pulse", chan_out, 1); chk("R10 new period", count_val, 6);
    do_load(3'd0, 16'd10);
    step(2); chk("R10 mode0 pre", count_val, 8);
    do_load(3'd0, 16'd3);
    chk("R10 mode0 immediate", count_val, 3); chk("R10 mode0 out", chan_out, 0);
  endtask

  task automatic t_retrig;
    gate_in = 1'b1;
    do_load(3'd2, 16'd5);
    step(2); chk("R11 rate count", count_val, 3);
    gate_in = 1'b0; step(1); chk("R11 rate gate hold", count_val, 3);
    gate_in = 1'b1; step(1); chk("R11 rate restart", count_val, 5); chk("R11 rate out", chan_out, 0);
    do_load(3'd3, 16'd6);
    step(2); chk("R11 sq count", count_val, 2); chk("R11 sq high", chan_out, 1);
    step(1); chk("R11 sq low", chan_out, 0);
    gate_in = 1'b0; step(1); chk("R11 sq hold", count_val, 6);
    gate_in = 1'b1; step(1); chk("R11 sq restart out", chan_out, 1); chk("R11 sq restart count", count_val, 6);
  endtask

  task automatic t_hold;
    do_load(3'd2, 16'd5);
    tick_en = 1'b0;
    step(4); chk("R12 count held", count_val, 5); chk("R12 out held", chan_out, 0);
    tick_en = 1'b1;
    step(1); chk("R12 resumes", count_val, 4);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    rst_n = 1'b0; tick_en = 1'b0; gate_in = 1'b1;
    load_stb = 1'b0; load_val = '0; mode_sel = '0;
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_mode0();
    t_zero();
    t_mode1();
    t_mode2();
    t_mode3();
    t_mode4();
    t_mode5();
    t_alias();
    t_defer();
    t_retrig();
    t_hold();
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule